// File: doc/BRIEF.md
# Dual-Edge Input Capture Cell

This block is the input-side register cell for a group of data pins. In single-data-rate mode each pin is registered once on the rising edge of the system clock. In double-data-rate mode a source-synchronous strobe samples every pin on both of its edges. The two resulting streams are aligned to the strobe's rising edge and then handed into the system clock domain through a pair of synchronization registers.

The synchronization registers can be clocked by either the true or the inverted system clock, chosen by a polarity input. Board and layout work use this to move the hand-over point by half a system period when the strobe-to-clock phase leaves too little margin on one edge. A delay-select input picks between a direct pin path and a fixed-delay path. Here the fixed delay is modelled with zero time, so it changes nothing that can be observed. The mode and polarity inputs are configuration: they are only changed while reset is held.

Top module: `ddr_in_capture`

## Requirements
- R1: Reset (`rst`, active high) acts asynchronously. While it is high both outputs are zero, without waiting for any clock edge, and every capture register inside the cell is cleared as well.
- R2: With `mode_ddr` = 0 (single-data-rate), each rising edge of `clk_sys` with `ce` = 1 loads `pin_d` into `q_even`. `q_odd` stays at zero throughout.
- R3: With `mode_ddr` = 1, a strobe rising edge forms a pair. `q_even` carries the pin value sampled at that rising edge. `q_odd` carries the value sampled at the strobe falling edge just before it. Both are presented together.
- R4: With `mode_ddr` = 1 and `sync_inv` = 0, the pair is moved onto the outputs at the rising edge of `clk_sys`. It is the pair formed by the latest strobe rising edge before that clock edge.
- R5: With `mode_ddr` = 1 and `sync_inv` = 1, the pair is moved onto the outputs at the falling edge of `clk_sys` instead. It is the pair formed by the latest strobe rising edge before that falling edge.
- R6: While `ce` = 0 both outputs hold their values. The strobe capture keeps sampling, so the first active system edge after `ce` returns to 1 delivers the newest pair, not a stale one.
- R7: `dly_en` selects the fixed-delay pin path (1) or the direct path (0). The outputs are identical for either setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| ce | input | 1 | Clock enable for the single-data-rate and synchronization registers |
| mode_ddr | input | 1 | 0 = single-data-rate, 1 = double-data-rate (static) |
| sync_inv | input | 1 | 1 = synchronization registers use the inverted system clock (static) |
| dly_en | input | 1 | 1 = route the pins through the fixed-delay path |
| strobe | input | 1 | Source-synchronous strobe |
| pin_d | input | LANES | Pin data |
| q_even | output | LANES | Rising-strobe stream, or the registered pin in single-data-rate mode |
| q_odd | output | LANES | Falling-strobe stream, zero in single-data-rate mode |

## Verification
In double-data-rate mode a pair is due at the first active system edge after the strobe rising edge that forms it. With polarity 0 that is the next rising edge; with polarity 1 it is the next falling edge. In single-data-rate mode the output is due at the next rising edge. The strobe rises 2.5 ns after each system rising edge, so the two polarities capture different pairs. The bench therefore samples 7 ns after each rising edge, after a falling-edge hand-over and before the next rising edge. The reference model updates its expected pair on the same edges and is compared at that sample point every cycle. The reset check samples 1 ns after reset rises, well before any clock edge.

// File: rtl/ddr_in_pkg.sv
package ddr_in_pkg;

  typedef enum logic {
    CAP_SDR = 1'b0,
    CAP_DDR = 1'b1
  } cap_mode_e;

  // Clock seen by the synchronization registers: true or inverted system clock.
  function automatic logic sync_clock(input logic clk, input logic inv);
    return clk ^ inv;
  endfunction

endpackage

// File: rtl/ddr_in_strobe_cap.sv
module ddr_in_strobe_cap #(
  parameter int W = 1
) (
  input  logic         strobe,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q
);

  logic [W-1:0] fall_raw;

  always_ff @(posedge strobe or posedge rst) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= d;
      fall_q <= fall_raw;
    end
  end

  always_ff @(negedge strobe or posedge rst) begin
    if (rst) fall_raw <= '0;
    else     fall_raw <= d;
  end

  // R3
  fall_retime_chk: assert property (@(posedge strobe) disable iff (rst)
    1'b1 |=> fall_q == $past(fall_raw));

  // R1
  cap_reset_chk: assert property (@(posedge strobe)
    rst |-> (rise_q == '0 && fall_q == '0 && fall_raw == '0));

endmodule

// File: rtl/ddr_in_sync_reg.sv
module ddr_in_sync_reg
  import ddr_in_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk_sys,
  input  logic         inv,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d_rise,
  input  logic [W-1:0] d_fall,
  output logic [W-1:0] q_rise,
  output logic [W-1:0] q_fall
);

  logic sclk;
  assign sclk = sync_clock(clk_sys, inv);

  always_ff @(posedge sclk or posedge rst) begin
    if (rst) begin
      q_rise <= '0;
      q_fall <= '0;
    end else if (ce) begin
      q_rise <= d_rise;
      q_fall <= d_fall;
    end
  end

  // R6
  sync_hold_chk: assert property (@(posedge sclk) disable iff (rst)
    !ce |=> ($stable(q_rise) && $stable(q_fall)));

  // R4
  sync_load_chk: assert property (@(posedge sclk) disable iff (rst)
    ce |=> (q_rise == $past(d_rise) && q_fall == $past(d_fall)));

endmodule

// File: rtl/ddr_in_sdr_reg.sv
module ddr_in_sdr_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)     q <= '0;
    else if (ce) q <= d;
  end

endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture
  import ddr_in_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk_sys,
  input  logic             rst,
  input  logic             ce,
  input  logic             mode_ddr,
  input  logic             sync_inv,
  input  logic             dly_en,
  input  logic             strobe,
  input  logic [LANES-1:0] pin_d,
  output logic [LANES-1:0] q_even,
  output logic [LANES-1:0] q_odd
);

  cap_mode_e        mode;
  logic [LANES-1:0] dly_path;
  logic [LANES-1:0] pin_sel;
  logic [LANES-1:0] cap_rise, cap_fall;
  logic [LANES-1:0] sync_rise, sync_fall;
  logic [LANES-1:0] sdr_q;

  assign mode = cap_mode_e'(mode_ddr);

  // Fixed-delay path carries no modelled delay.
  assign dly_path = pin_d;
  assign pin_sel  = dly_en ? dly_path : pin_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ddr_in_strobe_cap #(.W(1)) u_cap (
      .strobe (strobe),
      .rst    (rst),
      .d      (pin_sel[g]),
      .rise_q (cap_rise[g]),
      .fall_q (cap_fall[g])
    );
  end

  ddr_in_sync_reg #(.W(LANES)) u_sync (
    .clk_sys (clk_sys),
    .inv     (sync_inv),
    .rst     (rst),
    .ce      (ce),
    .d_rise  (cap_rise),
    .d_fall  (cap_fall),
    .q_rise  (sync_rise),
    .q_fall  (sync_fall)
  );

  ddr_in_sdr_reg #(.W(LANES)) u_sdr (
    .clk (clk_sys),
    .rst (rst),
    .ce  (ce),
    .d   (pin_sel),
    .q   (sdr_q)
  );

  always_comb begin
    if (mode == CAP_DDR) begin
      q_even = sync_rise;
      q_odd  = sync_fall;
    end else begin
      q_even = sdr_q;
      q_odd  = '0;
    end
  end

  // R2
  sdr_load_chk: assert property (@(posedge clk_sys) disable iff (rst)
    (!mode_ddr && ce) |=> q_even == $past(pin_d));

  // R2
  sdr_odd_zero_chk: assert property (@(posedge clk_sys) disable iff (rst)
    !mode_ddr |-> q_odd == '0);

  // R1
  out_reset_chk: assert property (@(posedge clk_sys)
    rst |-> (q_even == '0 && q_odd == '0));

endmodule

// File: tb/tb_ddr_in_capture.sv
`timescale 1ns/100ps
module tb_ddr_in_capture;

  localparam int LANES = 4;
  localparam logic [LANES-1:0] MASK = '1;

  logic clk_sys = 1'b0, rst = 1'b1, ce = 1'b1;
  logic mode_ddr = 1'b1, sync_inv = 1'b0, dly_en = 1'b0, strobe = 1'b0;
  logic [LANES-1:0] pin_d = '0, q_even, q_odd;

  int checks = 0, fails = 0;
  bit done = 0, chk_on = 0, r3_on = 0, pat_rand = 0;
  logic [LANES-1:0] pin_cnt = '0;

  ddr_in_capture #(.LANES(LANES)) dut (
    .clk_sys(clk_sys), .rst(rst), .ce(ce), .mode_ddr(mode_ddr),
    .sync_inv(sync_inv), .dly_en(dly_en), .strobe(strobe),
    .pin_d(pin_d), .q_even(q_even), .q_odd(q_odd)
  );

  always #5 clk_sys = ~clk_sys;
  initial begin
    #7.5;
    forever #5 strobe = ~strobe;
  end

  // Pin changes 1.25 ns after every strobe edge.
  always @(posedge strobe or negedge strobe) begin
    #1.25;
    pin_cnt = pin_cnt + 1'b1;
    pin_d = pat_rand ? LANES'($urandom) : pin_cnt;
  end

  // Reference model: history of strobe samples and expected outputs.
  logic [LANES-1:0] hist[$];
  logic [LANES-1:0] pr = '0, pf = '0, ee = '0, eo = '0;

  always @(posedge rst) begin
    hist = {};
    hist.push_back('0);
    pr = '0; pf = '0; ee = '0; eo = '0;
  end
  always @(posedge strobe) if (!rst) begin
    hist.push_back(pin_d);
    pr = hist[$];
    pf = hist[$-1];
    if (hist.size() > 8) void'(hist.pop_front());
  end
  always @(negedge strobe) if (!rst) hist.push_back(pin_d);

  always @(posedge clk_sys) if (!rst && ce) begin
    if (!mode_ddr) begin ee = pin_d; eo = '0; end
    else if (!sync_inv) begin ee = pr; eo = pf; end
  end
  always @(negedge clk_sys) if (!rst && ce && mode_ddr && sync_inv) begin
    ee = pr; eo = pf;
  end

  task automatic check(string tag, logic [LANES-1:0] ae, logic [LANES-1:0] ee_v,
                       logic [LANES-1:0] ao, logic [LANES-1:0] eo_v);
    checks++;
    if (ae !== ee_v || ao !== eo_v) begin
      fails++;
      $display("FAIL %s t=%0t q_even=%h exp=%h q_odd=%h exp=%h", tag, $time, ae, ee_v, ao, eo_v);
    end
  endtask

  function automatic string tag_now();
    if (dly_en) return "R7";
    if (!mode_ddr) return "R2";
    if (!ce) return "R6";
    return sync_inv ? "R5" : "R4";
  endfunction

  // Compare 7 ns after each rising edge: after a falling-edge hand-over.
  always @(posedge clk_sys) begin
    #7;
    if (chk_on) begin
      check(tag_now(), q_even, ee, q_odd, eo);
      if (r3_on) begin
        checks++;
        if (((q_even - q_odd) & MASK) !== 1) begin
          fails++;
          $display("FAIL R3 pair order q_even=%h q_odd=%h exp diff=1", q_even, q_odd);
        end
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk_sys);
    #1;
  endtask

  task automatic async_reset(logic ddr, logic inv);
    @(posedge clk_sys); #3;
    rst = 1'b1; chk_on = 0; r3_on = 0;
    #1;
    check("R1", q_even, '0, q_odd, '0);
    mode_ddr = ddr; sync_inv = inv;
    cycles(3);
    check("R1", q_even, '0, q_odd, '0);
    rst = 1'b0;
  endtask

  initial begin
    #3;
    check("R1", q_even, '0, q_odd, '0);
    cycles(2);
    check("R1", q_even, '0, q_odd, '0);
    rst = 1'b0; chk_on = 1;
    cycles(4); r3_on = 1;
    cycles(40);
    async_reset(1'b1, 1'b1);
    chk_on = 1;
    cycles(4); r3_on = 1;
    cycles(40);
    r3_on = 0; pat_rand = 1;
    for (int i = 0; i < 60; i++) begin
      ce = ($urandom_range(0, 2) != 0);
      cycles(1);
    end
    ce = 1'b1;
    async_reset(1'b1, 1'b0);
    chk_on = 1;
    for (int i = 0; i < 40; i++) begin
      ce = (i % 5 != 2);
      cycles(1);
    end
    ce = 1'b1; dly_en = 1'b1;
    cycles(30);
    dly_en = 1'b0;
    async_reset(1'b0, 1'b0);
    chk_on = 1;
    for (int i = 0; i < 40; i++) begin
      ce = (i % 7 != 3);
      cycles(1);
    end
    ce = 1'b1; dly_en = 1'b1;
    cycles(10);
    chk_on = 0; done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule